// File: doc/BRIEF.md
# PCM Highway Transmit Slot Serializer

This block places one channel's transmit data onto a shared time-division PCM highway. It runs on the highway bit clock. A frame-sync pulse marks the first bit of slot 0, and the block counts bit periods from that pulse. It finds the programmed slot and delays the start of that slot by a programmed skew of zero to seven bit periods. It then shifts out its data most significant bit first while raising an output enable, so that the pad can release the line during every other bit period.

Three transmit formats are supported. Companded mode sends one byte in one slot. Linear mode sends a 16-bit word across two consecutive slots. Signalling mode sends the companded byte and then a separately loaded signalling byte in the next slot, and the two bytes form one 16-bit block. Software-side data and configuration may change at any time. The block captures a copy of them at each frame sync, so a change made during a frame takes effect from the next frame onward.

The frame length is configured as the index of the last slot in the frame, from 1 to 127, which gives 2 to 128 slots. A two-slot transfer whose second slot would fall past the last slot is cut to its first byte rather than wrapping to slot 0.

Top module: `pcm_tx_slot`

## Requirements
- R1: After reset, and until the first frame sync has been sampled, `tx_oe` and `tx_bit` stay 0.
- R2: The bit period that follows a clock edge at which `fs` is sampled high is bit 0 of slot 0. Each later clock advances the bit position by one.
- R3: The first transmitted bit falls at bit position `slot*8 + skew`, where the slot number is 7 bits and the skew is 3 bits.
- R4: Each byte is transmitted most significant bit first.
- R5: When `cfg_mode` is 2'b00 or 2'b11 (companded), exactly 8 bits are sent, taken from `ld_word[15:8]`.
- R6: When `cfg_mode` is 2'b10 (linear), 16 bits of `ld_word` are sent, bit 15 first, across two consecutive slots.
- R7: When `cfg_mode` is 2'b01 (signalling), `ld_word[15:8]` is sent first and the 8-bit signalling byte follows in the next slot.
- R8: `tx_oe` is 1 exactly during the bit periods being transmitted. `tx_bit` is 0 whenever `tx_oe` is 0.
- R9: The data word, the signalling byte and all configuration inputs are captured at the edge that samples `fs`. A load or configuration change made at any other time affects only the next frame. A load presented in the same cycle as `fs` is used by the frame that starts there.
- R10: If a two-slot mode is programmed at the last slot of the frame (`cfg_slot == cfg_last`), only the first byte is sent. If `cfg_slot > cfg_last`, nothing is sent in that frame.
- R11: A frame sync that arrives while a transfer is in progress ends the transfer and restarts the bit count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs | input | 1 | Frame sync, one clock wide, marks slot 0 |
| ld_valid | input | 1 | Strobe that loads `ld_word` |
| ld_word | input | 16 | Companded byte in [15:8], or a 16-bit linear word |
| sig_valid | input | 1 | Strobe that loads `sig_byte` |
| sig_byte | input | 8 | Signalling byte for signalling mode |
| cfg_slot | input | 7 | Programmed time slot |
| cfg_skew | input | 3 | Slot start delay in bit periods |
| cfg_last | input | 7 | Index of the last slot in the frame |
| cfg_mode | input | 2 | 00/11 companded, 01 signalling, 10 linear |
| tx_bit | output | 1 | Serial data bit |
| tx_oe | output | 1 | Drive enable for the highway pad |

## Verification
Two events can fall in the same clock cycle: a new data load and the frame sync that captures data. In one case the bench presents `ld_valid` in the same cycle as `fs` and expects the new word in that frame. In another it presents a load mid-frame and expects the old word to be kept until the next frame. The other collision is a frame sync that lands while bits are still being shifted out. The bench provokes it with a shortened frame and expects transmission to stop at once and the count to restart at slot 0. A behavioural model in the bench predicts `tx_oe` and `tx_bit` for every bit period and is compared with the outputs on every clock. Each frame's count of enabled bit periods is also checked against the number the mode calls for.

// File: rtl/pcm_tx_pkg.sv
// Shared definitions for the PCM transmit slot serializer.
// Assumes eight-bit highway slots; mode encodings are fixed by the brief.
package pcm_tx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_COMP     = 2'b00,
        MODE_SIGNAL   = 2'b01,
        MODE_LINEAR   = 2'b10,
        MODE_COMP_ALT = 2'b11
    } tx_mode_e;

    // True when the mode occupies two consecutive slots.
    function automatic logic mode_two_slot(input logic [1:0] m);
        return (m == MODE_SIGNAL) || (m == MODE_LINEAR);
    endfunction

endpackage

// File: rtl/pcm_tx_bitpos.sv
// Bit position counter: restarts at 0 after each sampled frame sync and
// saturates at its top value. The framed flag records that at least one
// frame sync has been seen since reset.
// Assumes fs is a single-cycle pulse synchronous to clk.
module pcm_tx_bitpos #(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    output logic [POS_W-1:0] pos,
    output logic             framed
);

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    // Advance the position each clock; frame sync restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            framed <= 1'b0;
        end else if (fs) begin
            pos    <= '0;
            framed <= 1'b1;
        end else if (pos != POS_MAX) begin
            pos    <= pos + 1'b1;
        end
    end

    AST_FS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> (pos == '0) && framed); // R2

    AST_FRAMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        framed |=> framed); // R1

    AST_POS_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && framed) |=> (pos >= $past(pos))); // R2

endmodule

// File: rtl/pcm_tx_shadow.sv
// Frame shadow registers. Pending registers follow the load strobes at any
// time; the frame copy is taken only at frame sync, with a same-cycle load
// bypassing into the new frame. Configuration is copied at the same edge.
// Assumes the configuration inputs are quasi-static between frames.
module pcm_tx_shadow
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int SKEW_W = 3,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              sig_valid,
    input  logic [BYTE_W-1:0] sig_byte,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [SKEW_W-1:0] cfg_skew,
    input  logic [SLOT_W-1:0] cfg_last,
    input  logic [1:0]        cfg_mode,
    output logic [WORD_W-1:0] fr_word,
    output logic [BYTE_W-1:0] fr_sig,
    output logic [SLOT_W-1:0] fr_slot,
    output logic [SKEW_W-1:0] fr_skew,
    output logic [SLOT_W-1:0] fr_last,
    output logic [1:0]        fr_mode
);

    logic [WORD_W-1:0] pend_word;
    logic [BYTE_W-1:0] pend_sig;

    // Track the most recent load of each data source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_word <= '0;
            pend_sig  <= '0;
        end else begin
            if (ld_valid)  pend_word <= ld_word;
            if (sig_valid) pend_sig  <= sig_byte;
        end
    end

    // Take the per-frame copy of data and configuration at frame sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_word <= '0;
            fr_sig  <= '0;
            fr_slot <= '0;
            fr_skew <= '0;
            fr_last <= '0;
            fr_mode <= MODE_COMP;
        end else if (fs) begin
            fr_word <= ld_valid  ? ld_word  : pend_word;
            fr_sig  <= sig_valid ? sig_byte : pend_sig;
            fr_slot <= cfg_slot;
            fr_skew <= cfg_skew;
            fr_last <= cfg_last;
            fr_mode <= cfg_mode;
        end
    end

    AST_FRAME_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fs |=> ($stable(fr_word) && $stable(fr_sig))); // R9

    AST_FRAME_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fs |=> ($stable(fr_slot) && $stable(fr_skew) &&
                 $stable(fr_last) && $stable(fr_mode))); // R9

endmodule

// File: rtl/pcm_tx_window.sv
// Slot window comparator and bit selector. From the bit position and the
// frame copy it decides whether the current bit period is transmitted and,
// if so, which bit of the assembled word goes out, most significant first.
// Purely combinational; assumes the inputs are registered upstream.
module pcm_tx_window
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int SKEW_W = 3,
    parameter int POS_W  = 11,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  logic [POS_W-1:0]  pos,
    input  logic              framed,
    input  logic [WORD_W-1:0] fr_word,
    input  logic [BYTE_W-1:0] fr_sig,
    input  logic [SLOT_W-1:0] fr_slot,
    input  logic [SKEW_W-1:0] fr_skew,
    input  logic [SLOT_W-1:0] fr_last,
    input  logic [1:0]        fr_mode,
    output logic [POS_W-1:0]  start_pos,
    output logic              active,
    output logic              bit_out
);

    localparam int IDX_W  = $clog2(WORD_W);
    localparam int BYTE_SH = $clog2(BYTE_W);

    logic              slot_fits;
    logic              second_slot;
    logic [POS_W-1:0]  span;
    logic [POS_W-1:0]  offset;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] tx_word;

    // Start position of the programmed slot plus skew.
    always_comb begin
        start_pos = (POS_W'(fr_slot) << BYTE_SH) + POS_W'(fr_skew);
    end

    // Number of bits in this frame's transfer, cut at the frame end.
    always_comb begin
        slot_fits   = (fr_slot <= fr_last);
        second_slot = mode_two_slot(fr_mode) && (fr_slot != fr_last);
        span        = second_slot ? POS_W'(WORD_W) : POS_W'(BYTE_W);
    end

    // Transfer window test.
    always_comb begin
        offset = pos - start_pos;
        active = framed && slot_fits && (pos >= start_pos) && (offset < span);
    end

    // Word assembly for the selected mode.
    always_comb begin
        if (fr_mode == MODE_SIGNAL) begin
            tx_word = {fr_word[WORD_W-1 -: BYTE_W], fr_sig};
        end else begin
            tx_word = fr_word;
        end
    end

    // Pick the current bit, most significant first.
    always_comb begin
        idx     = IDX_W'(WORD_W - 1) - offset[IDX_W-1:0];
        bit_out = active ? tx_word[idx] : 1'b0;
    end

endmodule

// File: rtl/pcm_tx_slot.sv
// PCM highway transmit slot serializer, top level.
// Counts bit periods from frame sync, finds the programmed slot with its
// skew and shifts the captured data out with a drive enable.
// Assumes clk is the highway bit clock and fs is one clock wide.
module pcm_tx_slot
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int SKEW_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fs,
    input  logic                ld_valid,
    input  logic [2*BYTE_W-1:0] ld_word,
    input  logic                sig_valid,
    input  logic [BYTE_W-1:0]   sig_byte,
    input  logic [SLOT_W-1:0]   cfg_slot,
    input  logic [SKEW_W-1:0]   cfg_skew,
    input  logic [SLOT_W-1:0]   cfg_last,
    input  logic [1:0]          cfg_mode,
    output logic                tx_bit,
    output logic                tx_oe
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int POS_W  = SLOT_W + $clog2(BYTE_W) + 1;
    localparam int RUN_W  = $clog2(WORD_W) + 2;

    logic [POS_W-1:0]  pos;
    logic              framed;
    logic [WORD_W-1:0] fr_word;
    logic [BYTE_W-1:0] fr_sig;
    logic [SLOT_W-1:0] fr_slot;
    logic [SKEW_W-1:0] fr_skew;
    logic [SLOT_W-1:0] fr_last;
    logic [1:0]        fr_mode;
    logic [POS_W-1:0]  start_pos;
    logic              active;
    logic              bit_sel;

    pcm_tx_bitpos #(.POS_W(POS_W)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .fs     (fs),
        .pos    (pos),
        .framed (framed)
    );

    pcm_tx_shadow #(.SLOT_W(SLOT_W), .SKEW_W(SKEW_W), .WORD_W(WORD_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs        (fs),
        .ld_valid  (ld_valid),
        .ld_word   (ld_word),
        .sig_valid (sig_valid),
        .sig_byte  (sig_byte),
        .cfg_slot  (cfg_slot),
        .cfg_skew  (cfg_skew),
        .cfg_last  (cfg_last),
        .cfg_mode  (cfg_mode),
        .fr_word   (fr_word),
        .fr_sig    (fr_sig),
        .fr_slot   (fr_slot),
        .fr_skew   (fr_skew),
        .fr_last   (fr_last),
        .fr_mode   (fr_mode)
    );

    pcm_tx_window #(.SLOT_W(SLOT_W), .SKEW_W(SKEW_W), .POS_W(POS_W), .WORD_W(WORD_W)) u_win (
        .pos       (pos),
        .framed    (framed),
        .fr_word   (fr_word),
        .fr_sig    (fr_sig),
        .fr_slot   (fr_slot),
        .fr_skew   (fr_skew),
        .fr_last   (fr_last),
        .fr_mode   (fr_mode),
        .start_pos (start_pos),
        .active    (active),
        .bit_out   (bit_sel)
    );

    // Drive the highway outputs.
    always_comb begin
        tx_oe  = active;
        tx_bit = bit_sel;
    end

    // Length of the current enabled run, restarted by idle bits or frame sync.
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n || fs || !tx_oe) begin
            run_len <= '0;
        end else if (run_len != {RUN_W{1'b1}}) begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !framed |-> (!tx_oe && !tx_bit)); // R1

    AST_NO_BIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_bit); // R8

    AST_NOT_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> (pos >= start_pos)); // R3

    AST_RUN_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> (run_len < RUN_W'(WORD_W))); // R6

    AST_RUN_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && !mode_two_slot(fr_mode)) |-> (run_len < RUN_W'(BYTE_W))); // R5

    AST_NOTHING_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_slot > fr_last) |-> !tx_oe); // R10

endmodule

// File: tb/sim_pcm_tx_slot.sv
// Bench for pcm_tx_slot: a behavioural model predicts every bit period.
module sim_pcm_tx_slot;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        fs = 1'b0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_word = '0;
    logic        sig_valid = 1'b0;
    logic [7:0]  sig_byte = '0;
    logic [6:0]  cfg_slot = '0;
    logic [2:0]  cfg_skew = '0;
    logic [6:0]  cfg_last = 7'd3;
    logic [1:0]  cfg_mode = 2'b00;
    logic        tx_bit;
    logic        tx_oe;

    pcm_tx_slot u0 (
        .clk(clk), .rst_n(rst_n), .fs(fs),
        .ld_valid(ld_valid), .ld_word(ld_word),
        .sig_valid(sig_valid), .sig_byte(sig_byte),
        .cfg_slot(cfg_slot), .cfg_skew(cfg_skew), .cfg_last(cfg_last),
        .cfg_mode(cfg_mode), .tx_bit(tx_bit), .tx_oe(tx_oe)
    );

    int    checks = 0;
    int    fails  = 0;
    int    obs    = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // Behavioural model state.
    int          m_pos = 0;
    bit          m_framed = 1'b0;
    logic [15:0] m_pend = '0, m_word = '0;
    logic [7:0]  m_psig = '0, m_sig = '0;
    int          m_slot = 0, m_skew = 0, m_last = 0;
    logic [1:0]  m_mode = 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_framed = 0; m_pend = '0; m_psig = '0;
            m_word = '0; m_sig = '0; m_slot = 0; m_skew = 0; m_last = 0; m_mode = 2'b00;
        end else begin
            if (fs) begin
                m_framed = 1;
                m_pos    = 0;
                m_word   = ld_valid ? ld_word : m_pend;
                m_sig    = sig_valid ? sig_byte : m_psig;
                m_slot   = int'(cfg_slot);
                m_skew   = int'(cfg_skew);
                m_last   = int'(cfg_last);
                m_mode   = cfg_mode;
            end else if (m_pos < 2047) begin
                m_pos++;
            end
            if (ld_valid)  m_pend = ld_word;
            if (sig_valid) m_psig = sig_byte;
        end
    end

    // Compare the outputs with the model on every clock.
    always @(negedge clk) begin
        if (checking) begin
            int   start, nbits, off;
            bit   e_oe, e_bit;
            logic [15:0] w;
            start = m_slot * 8 + m_skew;
            if (m_slot > m_last) nbits = 0;
            else if ((m_mode == 2'b01 || m_mode == 2'b10) && m_slot != m_last) nbits = 16;
            else nbits = 8;
            e_oe  = m_framed && (m_pos >= start) && (m_pos < start + nbits);
            w     = (m_mode == 2'b01) ? {m_word[15:8], m_sig} : m_word;
            off   = m_pos - start;
            e_bit = e_oe ? w[15 - off] : 1'b0;
            checks++;
            if (tx_oe !== e_oe || tx_bit !== e_bit) begin
                fails++;
                $display("FAIL %s pos=%0d oe/bit=%b%b expected=%b%b", phase, m_pos, tx_oe, tx_bit, e_oe, e_bit);
            end
            if (tx_oe === 1'b1) obs++;
        end
    end

    logic        q_lv = 1'b0, q_sv = 1'b0;
    logic [15:0] q_w = '0;
    logic [7:0]  q_s = '0;

    task automatic step(input bit f);
        @(posedge clk); #2;
        fs = f;
        ld_valid = q_lv; ld_word = q_w; sig_valid = q_sv; sig_byte = q_s;
        q_lv = 1'b0; q_sv = 1'b0;
    endtask

    task automatic count_check(input int expv, input string tag);
        checks++;
        if (obs != expv) begin
            fails++;
            $display("FAIL %s enabled bits=%0d expected=%0d", tag, obs, expv);
        end
    endtask

    // One frame; observes bit positions 0..len-2 and checks the enabled count.
    task automatic frame(input int len, input int expv, input string tag);
        phase = tag;
        step(1'b1);
        @(negedge clk); #1 obs = 0;
        for (int i = 1; i < len; i++) step(1'b0);
        @(negedge clk); #1;
        count_check(expv, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk); #1;
        checks++;
        if (tx_oe !== 1'b0 || tx_bit !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset oe/bit=%b%b expected=00", tx_oe, tx_bit);
        end
        // R1: loads before any frame sync must not transmit.
        q_lv = 1'b1; q_w = 16'hFFFF;
        obs = 0;
        for (int i = 0; i < 6; i++) step(1'b0);
        @(negedge clk); #1;
        count_check(0, "R1 idle before sync");

        // R5 R2 R3 R4 R8: companded, slot 1, no skew.
        cfg_mode = 2'b00; cfg_slot = 7'd1; cfg_skew = 3'd0; cfg_last = 7'd3;
        q_lv = 1'b1; q_w = 16'hA53C;
        step(1'b0);
        frame(48, 8, "R5 R2 R4 companded");
        cfg_mode = 2'b11;
        frame(48, 8, "R5 alt companded code");

        // R6 R3: linear, slot 2, skew 3.
        cfg_mode = 2'b10; cfg_slot = 7'd2; cfg_skew = 3'd3;
        q_lv = 1'b1; q_w = 16'h9C71;
        step(1'b0);
        frame(48, 16, "R6 R3 linear skewed");

        // R7: signalling, slot 0, skew 7.
        cfg_mode = 2'b01; cfg_slot = 7'd0; cfg_skew = 3'd7;
        q_lv = 1'b1; q_w = 16'hE200; q_sv = 1'b1; q_s = 8'h5B;
        step(1'b0);
        frame(48, 16, "R7 signalling");

        // R10: second slot at frame end is cut; slot beyond the end sends nothing.
        cfg_mode = 2'b10; cfg_slot = 7'd3; cfg_skew = 3'd2;
        frame(48, 8, "R10 second slot cut");
        cfg_mode = 2'b01;
        frame(48, 8, "R10 signalling cut");
        cfg_slot = 7'd5;
        frame(48, 0, "R10 slot past end");

        // R9: mid-frame changes wait for the next frame.
        cfg_mode = 2'b00; cfg_slot = 7'd1; cfg_skew = 3'd0;
        phase = "R9 mid-frame change";
        step(1'b1);
        @(negedge clk); #1 obs = 0;
        for (int i = 1; i < 48; i++) begin
            if (i == 5) begin
                cfg_mode = 2'b10; cfg_slot = 7'd0;
                q_lv = 1'b1; q_w = 16'h1234;
            end
            step(1'b0);
        end
        @(negedge clk); #1;
        count_check(8, "R9 old config kept");
        frame(48, 16, "R9 new config applied");
        q_lv = 1'b1; q_w = 16'h3CC3;
        frame(48, 16, "R9 load with sync");

        // R11: early frame sync ends a transfer in progress.
        cfg_slot = 7'd1; cfg_skew = 3'd2;
        q_lv = 1'b1; q_w = 16'hF00F;
        frame(20, 9, "R11 truncated");
        frame(48, 16, "R11 restart after truncation");

        // R3 R10: largest slot and skew in a full 128-slot frame.
        cfg_last = 7'd127; cfg_slot = 7'd127; cfg_skew = 3'd7; cfg_mode = 2'b10;
        frame(1040, 8, "R3 R10 top slot");
        cfg_slot = 7'd126;
        frame(1040, 16, "R6 two top slots");

        done = 1'b1;
        checking = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule